// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block is the transmit half of a network controller's descriptor machinery. Software prepares a ring of transmit descriptors in a small on-block descriptor memory. Each descriptor has a control word with the frame length and three flags, followed by a pointer word with the byte address of the frame buffer. Once software has filled in a descriptor it sets the ownership flag. The engine walks the ring in order. For each owned descriptor it reads the buffer through a Wishbone master using block reads and pushes every data word into a downstream transmit FIFO. When the last word has gone into the FIFO, it returns the descriptor by clearing the ownership flag and, if asked to, pulses an interrupt.

The engine keeps its own position in the ring. Software therefore only has to remember which descriptor it will fill next, and it may reuse a descriptor once the ownership flag reads back as 0. The engine looks for new work only while the transmit-enable input is high. If the downstream FIFO fills up, the engine ends the bus cycle and starts a new one later at the address where it stopped.

Top module: `tx_desc_fetch`

## Requirements
- R1: While `tx_en` is 0 the engine starts no new descriptor. No bus cycle is raised and an owned descriptor keeps bit 15 at 1. A frame already in progress is finished.
- R2: Descriptors are taken in ring order from the current index, which is 0 after reset. If the descriptor at the current index has bit 15 at 0, the engine waits on that index and does not skip ahead to a later owned descriptor.
- R3: For a descriptor with length L (control bits 31:16, in bytes), the engine reads ceil(L/4) words. The reads start at the pointer word with its two low bits taken as 0, and go upward in address order. Each word is pushed to the FIFO, and `fifo_last` marks the final word. A descriptor with L = 0 causes no bus cycle and no push.
- R4: During a frame, `wb_cyc_o` and `wb_stb_o` are always equal. They stay high across back-to-back beats. The address steps by 4 bytes on each acknowledged beat and holds while no acknowledge arrives.
- R5: Whenever `fifo_full` is 1, `wb_cyc_o` and `wb_stb_o` are 0 in that same cycle, so no word is pushed into a full FIFO. When `fifo_full` falls, the bus cycle restarts at the next unread address, with no word lost or repeated.
- R6: After the frame's last word has been pushed, the control word is written back with bit 15 cleared and all other bits unchanged.
- R7: After each returned descriptor, the index goes back to 0 if its WRAP flag (bit 13) is set or it is the last descriptor (NUM_DESC-1). Otherwise the index goes up by 1.
- R8: `tx_irq` is a one-cycle pulse, raised once for each returned descriptor whose bit 14 is set. A descriptor with bit 14 clear raises no pulse.
- R9: Host word offset 0x800+2i holds the control word of descriptor i, and 0x801+2i holds its pointer. `host_rdata` shows the word addressed in the previous cycle. Offsets below 0x800, or at or above 0x800+2*NUM_DESC, ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable control bit |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the address |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_adr_o | output | ADDR_W | Wishbone byte address |
| wb_dat_i | input | DATA_W | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| fifo_push | output | 1 | Write one word into the transmit FIFO |
| fifo_data | output | DATA_W | Word pushed to the FIFO |
| fifo_last | output | 1 | Pushed word is the last of its frame |
| fifo_full | input | 1 | FIFO has no free entry |
| tx_irq | output | 1 | Transmit-done interrupt pulse |

## Verification
The bench builds the engine with NUM_DESC = 4 and the default 32-bit address and data widths. With four descriptors, the wrap-at-last-index case comes up after a handful of frames, and the explicit WRAP flag and the no-skip stall can be tested on neighbouring indices. An alias check at offset 0x808 also falls just past the window. The FIFO model's capacity can be shrunk to four entries, so a ten-word frame forces the bus cycle to stop and restart. A pseudo-random acknowledge gate adds wait states between beats.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int CW        = 32;  // descriptor word width
  localparam int OWN_BIT   = 15;  // hardware owns the descriptor
  localparam int IRQ_BIT   = 14;  // pulse interrupt on hand-back
  localparam int WRAP_BIT  = 13;  // return to index 0 after this one
  localparam int LEN_LSB   = 16;
  localparam int LEN_W     = 16;

  typedef enum logic [2:0] {
    ST_POLL,
    ST_CTRL,
    ST_PTR,
    ST_XFER,
    ST_BACK
  } ring_st_t;
endpackage

// File: rtl/tx_desc_ram.sv
module tx_desc_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  // engine write is placed last so it wins a same-address collision
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/tx_wb_reader.sv
module tx_wb_reader #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16,
  localparam int OFF  = $clog2(DW/8),
  localparam int WAW  = AW - OFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic [CNT_W-1:0] start_words,
  input  logic             fifo_full,
  output logic             wb_cyc_o,
  output logic             wb_stb_o,
  output logic [AW-1:0]    wb_adr_o,
  input  logic [DW-1:0]    wb_dat_i,
  input  logic             wb_ack_i,
  output logic             fifo_push,
  output logic [DW-1:0]    fifo_data,
  output logic             fifo_last,
  output logic             busy,
  output logic             done
);
  logic [WAW-1:0]   wadr_q;
  logic [CNT_W-1:0] left_q;
  logic             busy_q;
  logic             done_q;
  logic             beat;
  logic [OFF-1:0]   unused_lo;

  assign unused_lo = start_addr[OFF-1:0];

  // both strobes held for the whole burst, withdrawn while the FIFO is full
  assign wb_cyc_o  = busy_q & ~fifo_full;
  assign wb_stb_o  = busy_q & ~fifo_full;
  assign wb_adr_o  = {wadr_q, {OFF{1'b0}}};
  assign beat      = wb_cyc_o & wb_ack_i;

  assign fifo_push = beat;
  assign fifo_data = wb_dat_i;
  assign fifo_last = beat & (left_q == CNT_W'(1));
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wadr_q <= '0;
      left_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        wadr_q <= start_addr[AW-1:OFF];
        left_q <= start_words;
      end else if (beat) begin
        wadr_q <= wadr_q + WAW'(1);
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
  import txd_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int AW       = 32,
  parameter int DW       = 32,
  localparam int IDX_W   = $clog2(NUM_DESC),
  localparam int RAW     = IDX_W + 1,
  localparam int BYTES   = DW / 8,
  localparam int OFF     = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  output logic [RAW-1:0]   ram_addr,
  output logic             ram_we,
  output logic [CW-1:0]    ram_wdata,
  input  logic [CW-1:0]    ram_rdata,
  output logic             rd_start,
  output logic [AW-1:0]    rd_addr,
  output logic [LEN_W-1:0] rd_words,
  input  logic             rd_done,
  output logic             tx_irq
);
  ring_st_t         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [CW-1:0]    ctrl_q;
  logic             start_q;
  logic             irq_q;
  logic [AW-1:0]    addr_q;
  logic [LEN_W-1:0] words_q;
  logic [LEN_W:0]   len_round;
  logic [LEN_W-1:0] words_nxt;

  always_comb begin
    len_round = {1'b0, ctrl_q[LEN_LSB +: LEN_W]} + (LEN_W+1)'(BYTES - 1);
    words_nxt = LEN_W'(len_round >> OFF);
  end

  assign ram_addr  = {idx_q, (st_q == ST_CTRL)};
  assign ram_we    = (st_q == ST_BACK);
  assign ram_wdata = ctrl_q & ~(CW'(1) << OWN_BIT);
  assign rd_start  = start_q;
  assign rd_addr   = addr_q;
  assign rd_words  = words_q;
  assign tx_irq    = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_POLL;
      idx_q   <= '0;
      ctrl_q  <= '0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      addr_q  <= '0;
      words_q <= '0;
    end else begin
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      case (st_q)
        ST_POLL: if (tx_en) st_q <= ST_CTRL;
        ST_CTRL: begin
          ctrl_q <= ram_rdata;
          st_q   <= ram_rdata[OWN_BIT] ? ST_PTR : ST_POLL;
        end
        ST_PTR: begin
          if (words_nxt == '0) begin
            st_q <= ST_BACK;
          end else begin
            addr_q  <= AW'(ram_rdata);
            words_q <= words_nxt;
            start_q <= 1'b1;
            st_q    <= ST_XFER;
          end
        end
        ST_XFER: if (rd_done) st_q <= ST_BACK;
        ST_BACK: begin
          irq_q <= ctrl_q[IRQ_BIT];
          if (ctrl_q[WRAP_BIT] || idx_q == IDX_W'(NUM_DESC - 1))
            idx_q <= '0;
          else
            idx_q <= idx_q + IDX_W'(1);
          st_q <= ST_POLL;
        end
        default: st_q <= ST_POLL;
      endcase
    end
  end
endmodule

// File: rtl/tx_desc_fetch.sv
module tx_desc_fetch
  import txd_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  localparam int RAW     = $clog2(NUM_DESC) + 1,
  localparam int DEPTH   = 2 ** RAW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              host_we,
  input  logic [11:0]       host_addr,
  input  logic [CW-1:0]     host_wdata,
  output logic [CW-1:0]     host_rdata,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic              wb_ack_i,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_data,
  output logic              fifo_last,
  input  logic              fifo_full,
  output logic              tx_irq
);
  logic             host_hit;
  logic             hit_q;
  logic [CW-1:0]    a_rdata;
  logic [RAW-1:0]   eng_addr;
  logic             eng_we;
  logic [CW-1:0]    eng_wdata;
  logic [CW-1:0]    eng_rdata;
  logic             rd_start;
  logic [ADDR_W-1:0] rd_addr;
  logic [LEN_W-1:0] rd_words;
  logic             rd_done;
  logic             rd_busy;

  // descriptor window: upper half of the 4K-word space, 2 words per entry
  assign host_hit = host_addr[11] &&
                    ({1'b0, host_addr[10:0]} < 12'(2 * NUM_DESC));

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= host_hit;
  end

  assign host_rdata = hit_q ? a_rdata : '0;

  tx_desc_ram #(.DEPTH(DEPTH), .DW(CW)) u_ram (
    .clk     (clk),
    .a_we    (host_we & host_hit),
    .a_addr  (host_addr[RAW-1:0]),
    .a_wdata (host_wdata),
    .a_rdata (a_rdata),
    .b_we    (eng_we),
    .b_addr  (eng_addr),
    .b_wdata (eng_wdata),
    .b_rdata (eng_rdata)
  );

  tx_desc_ring #(.NUM_DESC(NUM_DESC), .AW(ADDR_W), .DW(DATA_W)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .ram_addr  (eng_addr),
    .ram_we    (eng_we),
    .ram_wdata (eng_wdata),
    .ram_rdata (eng_rdata),
    .rd_start  (rd_start),
    .rd_addr   (rd_addr),
    .rd_words  (rd_words),
    .rd_done   (rd_done),
    .tx_irq    (tx_irq)
  );

  tx_wb_reader #(.AW(ADDR_W), .DW(DATA_W), .CNT_W(LEN_W)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .start       (rd_start),
    .start_addr  (rd_addr),
    .start_words (rd_words),
    .fifo_full   (fifo_full),
    .wb_cyc_o    (wb_cyc_o),
    .wb_stb_o    (wb_stb_o),
    .wb_adr_o    (wb_adr_o),
    .wb_dat_i    (wb_dat_i),
    .wb_ack_i    (wb_ack_i),
    .fifo_push   (fifo_push),
    .fifo_data   (fifo_data),
    .fifo_last   (fifo_last),
    .busy        (rd_busy),
    .done        (rd_done)
  );
endmodule

// File: rtl/tx_desc_fetch_chk.sv
module tx_desc_fetch_chk #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wb_cyc_o,
  input logic          wb_ack_i,
  input logic [AW-1:0] wb_adr_o,
  input logic          fifo_push,
  input logic          fifo_last,
  input logic          fifo_full,
  input logic          tx_irq,
  input logic          rd_start,
  input logic          rd_busy
);
  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && wb_ack_i && !fifo_last) |=> (wb_adr_o == $past(wb_adr_o) + AW'(STEP)));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && !wb_ack_i) |=> $stable(wb_adr_o));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> !fifo_full);

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);

  p_start_idle_r3: assert property (@(posedge clk) disable iff (rst)
    rd_start |-> !rd_busy);

  p_last_is_push_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_last |-> fifo_push);
endmodule

bind tx_desc_fetch tx_desc_fetch_chk #(.AW(ADDR_W), .STEP(DATA_W/8)) u_chk (.*);

// File: tb/tx_desc_fetch_test.sv
`timescale 1ns/1ps
module tx_desc_fetch_test;
  localparam int ND = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        wb_cyc_o, wb_stb_o, wb_ack_i;
  logic [31:0] wb_adr_o, wb_dat_i;
  logic        fifo_push, fifo_last, fifo_full, tx_irq;
  logic [31:0] fifo_data;

  int n_chk = 0, n_bad = 0;
  int cap = 64, cnt = 0, ovf = 0, nrx = 0;
  int irq_n = 0, cyc_n = 0, stb_mis = 0, full_bus = 0;
  logic pop_en = 1'b1;
  logic slow = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  logic [31:0] rxd [256];
  logic        rxl [256];
  bit finished = 0;

  always #2 clk = ~clk;

  tx_desc_fetch #(.NUM_DESC(ND)) uut (
    .clk(clk), .rst(rst), .tx_en(tx_en),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_adr_o(wb_adr_o), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i),
    .fifo_push(fifo_push), .fifo_data(fifo_data), .fifo_last(fifo_last), .fifo_full(fifo_full),
    .tx_irq(tx_irq)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return 32'h5A00_0000 ^ {a[7:0], a[15:8], a[31:16]};
  endfunction

  function automatic logic [31:0] mkctrl(input int len, input bit irq, input bit wrap, input logic [12:0] rsv);
    return {16'(len), 1'b1, irq, wrap, rsv};
  endfunction

  assign wb_dat_i  = mem_word(wb_adr_o);
  assign wb_ack_i  = wb_cyc_o & wb_stb_o & (slow ? lfsr[0] : 1'b1);
  assign fifo_full = (cnt >= cap);

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (fifo_push) begin
      if (cnt >= cap) ovf++;
      if (nrx < 256) begin
        rxd[nrx] = fifo_data;
        rxl[nrx] = fifo_last;
      end
      nrx++;
    end
    if (tx_irq) irq_n++;
    if (wb_cyc_o) cyc_n++;
    if (wb_cyc_o !== wb_stb_o) stb_mis++;
    if (fifo_full && wb_cyc_o) full_bus++;
    cnt <= cnt + (fifo_push ? 1 : 0) - ((pop_en && cnt > 0) ? 1 : 0);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_we = 1'b0;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic set_desc(input int i, input logic [31:0] ctrl, input logic [31:0] ptr);
    host_wr(12'(12'h801 + 2*i), ptr);
    host_wr(12'(12'h800 + 2*i), ctrl);
  endtask

  task automatic wait_back(input int i, input string tag);
    logic [31:0] d;
    int k;
    for (k = 0; k < 3000; k++) begin
      host_rd(12'(12'h800 + 2*i), d);
      if (!d[15]) break;
    end
    if (k == 3000) chk({tag, " hand-back timeout"}, 32'(d[15]), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_frame(input string tag, input int base, input logic [31:0] ptr, input int nw);
    for (int k = 0; k < nw; k++) begin
      chk({tag, " data"}, rxd[base+k], mem_word((ptr & 32'hFFFF_FFFC) + 32'(4*k)));
      chk({tag, " last flag"}, 32'(rxl[base+k]), 32'(k == nw-1));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset cyc", 32'(wb_cyc_o), 0);
    chk("R5 reset push", 32'(fifo_push), 0);
    chk("R8 reset irq", 32'(tx_irq), 0);
    chk("R9 reset rdata", host_rdata, 0);
  endtask

  // desc0: held back by tx_en, then sent as a 2-word frame with irq
  task automatic t_enable;
    logic [31:0] d;
    int b, ib;
    b = nrx; ib = irq_n;
    set_desc(0, mkctrl(8, 1, 0, 13'h0), 32'h0000_0100);
    repeat (40) @(negedge clk);
    chk("R1 no bus while disabled", 32'(cyc_n), 0);
    host_rd(12'h800, d);
    chk("R1 owner bit kept", 32'(d[15]), 1);
    tx_en = 1'b1;
    wait_back(0, "R1");
    chk("R3 word count 8B", 32'(nrx - b), 2);
    chk_frame("R3 8B frame", b, 32'h100, 2);
    chk("R8 irq once", 32'(irq_n - ib), 1);
  endtask

  // desc1: 10 bytes -> 3 words, misaligned pointer, reserved bits preserved
  task automatic t_odd_len;
    logic [31:0] d;
    int b, ib;
    b = nrx; ib = irq_n;
    set_desc(1, mkctrl(10, 0, 0, 13'h0155), 32'h0000_0203);
    wait_back(1, "R3");
    chk("R3 word count 10B", 32'(nrx - b), 3);
    chk_frame("R3 10B frame", b, 32'h200, 3);
    host_rd(12'h802, d);
    chk("R6 write-back", d, mkctrl(10, 0, 0, 13'h0155) & ~32'h8000);
    chk("R8 no irq when disabled", 32'(irq_n - ib), 0);
  endtask

  // desc2: zero length
  task automatic t_zero;
    int b, cb;
    b = nrx; cb = cyc_n;
    set_desc(2, mkctrl(0, 0, 0, 13'h0), 32'h0000_0300);
    wait_back(2, "R3");
    chk("R3 zero length no push", 32'(nrx - b), 0);
    chk("R3 zero length no bus", 32'(cyc_n - cb), 0);
  endtask

  // desc3 is the last index: ring returns to 0
  task automatic t_last_index;
    int b;
    b = nrx;
    set_desc(3, mkctrl(4, 1, 0, 13'h0), 32'h0000_0400);
    wait_back(3, "R7");
    chk("R7 last desc word", rxd[b], mem_word(32'h400));
  endtask

  // stall on an unowned index, WRAP flag, then ring order 0 -> 1
  task automatic t_ring;
    logic [31:0] d;
    int b;
    slow = 1'b1;
    b = nrx;
    set_desc(1, mkctrl(4, 0, 0, 13'h0), 32'h0000_0500);
    repeat (40) @(negedge clk);
    host_rd(12'h802, d);
    chk("R2 no skip past unowned index", 32'(d[15]), 1);
    chk("R2 no push while stalled", 32'(nrx - b), 0);
    set_desc(0, mkctrl(4, 1, 1, 13'h0), 32'h0000_0510);
    wait_back(0, "R7");
    repeat (40) @(negedge clk);
    host_rd(12'h802, d);
    chk("R7 wrap flag returns to 0", 32'(d[15]), 1);
    chk("R7 wrap one word", 32'(nrx - b), 1);
    chk("R7 wrap frame data", rxd[b], mem_word(32'h510));
    set_desc(0, mkctrl(4, 0, 0, 13'h0), 32'h0000_0520);
    wait_back(1, "R2");
    chk("R2 order first", rxd[b+1], mem_word(32'h520));
    chk("R2 order second", rxd[b+2], mem_word(32'h500));
  endtask

  // desc2: 10-word frame into a 4-entry FIFO that is not drained
  task automatic t_backpressure;
    logic [31:0] d;
    int b;
    b = nrx;
    cap = 4; pop_en = 1'b0;
    set_desc(2, mkctrl(40, 0, 0, 13'h0), 32'h0000_0600);
    repeat (80) @(negedge clk);
    chk("R5 stops at capacity", 32'(nrx - b), 4);
    chk("R5 bus released when full", 32'(wb_cyc_o), 0);
    host_rd(12'h804, d);
    chk("R6 not returned early", 32'(d[15]), 1);
    pop_en = 1'b1;
    wait_back(2, "R5");
    chk("R5 word count after resume", 32'(nrx - b), 10);
    chk_frame("R5 resumed frame", b, 32'h600, 10);
    chk("R5 no overflow", 32'(ovf), 0);
    chk("R5 no bus while full", 32'(full_bus), 0);
    cap = 64;
  endtask

  // desc3: 5-word frame under wait states
  task automatic t_wait_states;
    int b, ib;
    b = nrx; ib = irq_n;
    set_desc(3, mkctrl(20, 1, 0, 13'h0), 32'h0000_0700);
    wait_back(3, "R4");
    chk_frame("R4 wait-state frame", b, 32'h700, 5);
    chk("R4 strobe equals cycle", 32'(stb_mis), 0);
    chk("R8 irq once per frame", 32'(irq_n - ib), 1);
  endtask

  task automatic t_window;
    logic [31:0] d0, d;
    host_rd(12'h800, d0);
    host_wr(12'(12'h800 + 2*ND), 32'hDEAD_BEEF);
    host_rd(12'(12'h800 + 2*ND), d);
    chk("R9 past window reads 0", d, 0);
    host_rd(12'h800, d);
    chk("R9 past window no alias", d, d0);
    host_wr(12'h005, 32'h1234_5678);
    host_rd(12'h005, d);
    chk("R9 below window reads 0", d, 0);
    host_rd(12'h807, d);
    chk("R9 pointer readback", d, 32'h0000_0700);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_enable();
    t_odd_len();
    t_zero();
    t_last_index();
    t_ring();
    t_backpressure();
    t_wait_states();
    t_window();
    finished = 1;
    summary();
    $finish;
  end
endmodule